// File: doc/BRIEF.md
# Error Flag Host Access Port

This block gives a host controller synchronous access to a bank of video error-detection flags over one shared 5-bit bus that can be driven from either side. A direction input chooses between writing and reading, and a 2-bit group select picks the part of the bank involved. The bus is carried as separate input, output and output-enable signals, so a tri-state pad outside the block can join them.

The bank holds two copies of the fifteen error flags. The incoming copy is loaded by the checker side through a load strobe. The outgoing copy also takes the loaded values, and the host may then overwrite it group by group. Beside the flags, the bank keeps two validity bits, an outgoing checksum-error flag, a status bit, and a persistent control bit. The control bit decides which copy of the flags host reads return.

Whenever the direction changes, the bus turns around on the first sampled cycle of the new mode. Read data comes out one clock after the select is sampled.

Top module: `flag_host_port`

## Requirements
- R1: At a rising edge where `dir_rd` is sampled 0 and the previous sample was 1 (or reset has just been released), nothing in the bank is written. From the next cycle `bus_oe` is 0, and it stays 0 while `dir_rd` stays 0.
- R2: At each later rising edge with `dir_rd` still 0, `bus_in` is written into the outgoing group named by `grp_sel`: 0 selects full-field, 1 active-picture, 2 ancillary. In every group, bits 4 down to 0 are the UES, IDA, IDH, EDA and EDH flags.
- R3: Such a write with `grp_sel` = 3 loads the control bit from `bus_in[4]`, the active-picture validity bit from `bus_in[3]` and the full-field validity bit from `bus_in[2]`. `bus_in[1:0]` are ignored.
- R4: A write changes only the group named by `grp_sel`. All other outgoing groups keep their values.
- R5: At a rising edge where `dir_rd` is sampled 1, `bus_oe` is 1 from the next cycle. `bus_out` then carries the data for the `grp_sel` sampled at that edge, built from the bank contents before that edge.
- R6: A read of group 0, 1 or 2 returns the incoming flags of that group when the control bit is 1, and the outgoing flags when it is 0.
- R7: A read with `grp_sel` = 3 returns `{cks, apv, ffv, status, 0}` on bits 4..0. Bit 4 is the checksum-error flag when the control bit is 0 and reads 0 when it is 1. The validity bits and the status bit do not depend on the control bit.
- R8: The control bit is 0 after reset and holds until a group-3 write changes it. Its value has no effect on where a write lands: with the control bit at 1, writes still go to the outgoing groups.
- R9: When `chk_load` is 1 at a rising edge, all three incoming groups and all three outgoing groups take `chk_ff`, `chk_ap` and `chk_anc`. The validity bits, the checksum flag and the status bit take their `chk_` inputs in the same edge. If a host write happens at that same edge, the host write wins for whatever it writes.
- R10: During reset `bus_oe` and `bus_out` are 0, and every flag, validity, checksum, status and control bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rd | input | 1 | 1 = read mode, 0 = write mode |
| grp_sel | input | 2 | Group select |
| bus_in | input | 5 | Bus value seen at the pad |
| bus_out | output | 5 | Registered read data |
| bus_oe | output | 1 | Registered bus drive enable |
| chk_load | input | 1 | Checker-side load strobe |
| chk_ff | input | 5 | Full-field flags to load |
| chk_ap | input | 5 | Active-picture flags to load |
| chk_anc | input | 5 | Ancillary flags to load |
| chk_apv | input | 1 | Active-picture validity to load |
| chk_ffv | input | 1 | Full-field validity to load |
| chk_cks | input | 1 | Checksum-error flag to load |
| chk_status | input | 1 | Status bit to load |

## Verification
The bench goes after the turnaround cycle. A design that writes on the first low sample would corrupt a group with bus data the host never meant to commit, and one that drives on that sample would collide with the host on the bus. It checks that a group write leaves the other groups alone, since a decode slip would clear or copy neighbouring flags. It reads group 3 with the control bit at both values, where a wrong source mux would leak the checksum flag or take the validity bits from the wrong place. It also fires a load and a host write at the same edge, where wrong priority would silently drop what the host wrote.

// File: rtl/flag_port_pkg.sv
package flag_port_pkg;
  localparam int FLAG_W  = 5;
  localparam int NUM_GRP = 3;
  localparam int SEL_W   = 2;
  localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_GRP);
  typedef logic [FLAG_W-1:0] flag_grp_t;
  typedef flag_grp_t [NUM_GRP-1:0] flag_bank_t;
endpackage

// File: rtl/port_turn_ctrl.sv
module port_turn_ctrl
  import flag_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dir_rd,
  input  flag_grp_t rd_word,
  output logic      wr_en,
  output logic      bus_oe,
  output flag_grp_t bus_out
);
  logic      dir_q, dir_d;
  logic      oe_q, oe_d;
  flag_grp_t rd_q, rd_d;

  always_comb begin
    wr_en = !dir_rd && !dir_q;
    dir_d = dir_rd;
    oe_d  = dir_rd;
    rd_d  = rd_q;
    if (dir_rd) rd_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b1;
      oe_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      dir_q <= dir_d;
      oe_q  <= oe_d;
      rd_q  <= rd_d;
    end
  end

  assign bus_oe  = oe_q;
  assign bus_out = rd_q;
endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  flag_grp_t        wr_data,
  input  logic             ld,
  input  flag_bank_t       ld_flags,
  input  logic             ld_apv,
  input  logic             ld_ffv,
  input  logic             ld_cks,
  input  logic             ld_st,
  output flag_bank_t       inc_flags,
  output flag_bank_t       out_flags,
  output logic             apv,
  output logic             ffv,
  output logic             cks,
  output logic             st,
  output logic             ctl
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    flag_grp_t inc_q, inc_d, out_q, out_d;
    always_comb begin
      inc_d = inc_q;
      out_d = out_q;
      if (ld) begin
        inc_d = ld_flags[g];
        out_d = ld_flags[g];
      end
      if (wr_en && (wr_sel == SEL_W'(g))) out_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inc_q <= '0;
        out_q <= '0;
      end else begin
        inc_q <= inc_d;
        out_q <= out_d;
      end
    end
    assign inc_flags[g] = inc_q;
    assign out_flags[g] = out_q;
  end

  logic apv_q, ffv_q, cks_q, st_q, ctl_q;
  logic apv_d, ffv_d, cks_d, st_d, ctl_d;
  logic ctrl_wr;

  always_comb begin
    ctrl_wr = wr_en && (wr_sel == CTRL_SEL);
    apv_d = apv_q;
    ffv_d = ffv_q;
    cks_d = cks_q;
    st_d  = st_q;
    ctl_d = ctl_q;
    if (ld) begin
      apv_d = ld_apv;
      ffv_d = ld_ffv;
      cks_d = ld_cks;
      st_d  = ld_st;
    end
    if (ctrl_wr) begin
      ctl_d = wr_data[4];
      apv_d = wr_data[3];
      ffv_d = wr_data[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apv_q <= 1'b0;
      ffv_q <= 1'b0;
      cks_q <= 1'b0;
      st_q  <= 1'b0;
      ctl_q <= 1'b0;
    end else begin
      apv_q <= apv_d;
      ffv_q <= ffv_d;
      cks_q <= cks_d;
      st_q  <= st_d;
      ctl_q <= ctl_d;
    end
  end

  assign apv = apv_q;
  assign ffv = ffv_q;
  assign cks = cks_q;
  assign st  = st_q;
  assign ctl = ctl_q;
endmodule

// File: rtl/flag_read_mux.sv
module flag_read_mux
  import flag_port_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             ctl,
  input  flag_bank_t       inc_flags,
  input  flag_bank_t       out_flags,
  input  logic             apv,
  input  logic             ffv,
  input  logic             cks,
  input  logic             st,
  output flag_grp_t        rd_word
);
  always_comb begin
    rd_word = {(cks && !ctl), apv, ffv, st, 1'b0};
    for (int g = 0; g < NUM_GRP; g++) begin
      if (sel == SEL_W'(g)) rd_word = ctl ? inc_flags[g] : out_flags[g];
    end
  end
endmodule

// File: rtl/flag_host_port.sv
module flag_host_port
  import flag_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic [SEL_W-1:0] grp_sel,
  input  logic [4:0]       bus_in,
  output logic [4:0]       bus_out,
  output logic             bus_oe,
  input  logic             chk_load,
  input  logic [4:0]       chk_ff,
  input  logic [4:0]       chk_ap,
  input  logic [4:0]       chk_anc,
  input  logic             chk_apv,
  input  logic             chk_ffv,
  input  logic             chk_cks,
  input  logic             chk_status
);
  flag_bank_t ld_flags, inc_flags, out_flags;
  flag_grp_t  rd_word;
  logic       wr_en, apv_q, ffv_q, cks_q, st_q, ctl_q;

  assign ld_flags[0] = chk_ff;
  assign ld_flags[1] = chk_ap;
  assign ld_flags[2] = chk_anc;

  port_turn_ctrl u_turn (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .rd_word(rd_word),
    .wr_en(wr_en), .bus_oe(bus_oe), .bus_out(bus_out)
  );

  flag_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(grp_sel),
    .wr_data(bus_in), .ld(chk_load), .ld_flags(ld_flags),
    .ld_apv(chk_apv), .ld_ffv(chk_ffv), .ld_cks(chk_cks),
    .ld_st(chk_status), .inc_flags(inc_flags), .out_flags(out_flags),
    .apv(apv_q), .ffv(ffv_q), .cks(cks_q), .st(st_q), .ctl(ctl_q)
  );

  flag_read_mux u_mux (
    .sel(grp_sel), .ctl(ctl_q), .inc_flags(inc_flags),
    .out_flags(out_flags), .apv(apv_q), .ffv(ffv_q), .cks(cks_q),
    .st(st_q), .rd_word(rd_word)
  );
endmodule

// File: rtl/flag_host_port_checker.sv
module flag_host_port_checker
  import flag_port_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dir_rd,
  input logic [SEL_W-1:0] grp_sel,
  input logic [4:0]       bus_in,
  input logic [4:0]       bus_out,
  input logic             bus_oe,
  input logic             chk_load,
  input flag_bank_t       inc_flags,
  input flag_bank_t       out_flags,
  input logic             ctl_q,
  input logic             st_q
);
  logic prev_dir;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_dir <= 1'b1;
    else        prev_dir <= dir_rd;
  end

  logic host_wr;
  assign host_wr = !dir_rd && !prev_dir;

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_rd |=> !bus_oe);
  assert_first_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && prev_dir && !chk_load) |=> ($stable(out_flags) && $stable(ctl_q)));
  assert_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rd |=> bus_oe);
  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && grp_sel == 2'd1 && !chk_load) |=>
      ($stable(out_flags[0]) && $stable(out_flags[2])));
  assert_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && grp_sel == 2'd0 && ctl_q) |=> (bus_out == $past(inc_flags[0])));
  assert_ctrl_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && grp_sel == 2'd3) |=> (!bus_out[0] && bus_out[1] == $past(st_q)));
  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && grp_sel == 2'd3) |=> $stable(ctl_q));
  assert_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_load && host_wr && grp_sel == 2'd0) |=> (out_flags[0] == $past(bus_in)));
endmodule

bind flag_host_port flag_host_port_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .grp_sel(grp_sel),
  .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .chk_load(chk_load),
  .inc_flags(inc_flags), .out_flags(out_flags), .ctl_q(ctl_q), .st_q(st_q)
);

// File: tb/test_flag_host_port.sv
module test_flag_host_port;
  logic       clk, rst_n, dir_rd, chk_load;
  logic [1:0] grp_sel;
  logic [4:0] bus_in, bus_out, chk_ff, chk_ap, chk_anc;
  logic       bus_oe, chk_apv, chk_ffv, chk_cks, chk_status;

  flag_host_port i_flag_host_port (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  // reference state
  logic [4:0] m_inc [3];
  logic [4:0] m_out [3];
  logic m_apv, m_ffv, m_cks, m_st, m_ctl, m_prev, e_oe;
  logic [4:0] e_out;

  function automatic logic [4:0] ref_read(input logic [1:0] s);
    if (s == 2'd3) return {m_cks & ~m_ctl, m_apv, m_ffv, m_st, 1'b0};
    return m_ctl ? m_inc[s] : m_out[s];
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 3; g++) begin m_inc[g] = '0; m_out[g] = '0; end
    m_apv = 0; m_ffv = 0; m_cks = 0; m_st = 0; m_ctl = 0; m_prev = 1;
    e_oe = 0; e_out = '0;
  endtask

  task automatic model_edge();
    logic wr;
    wr = !dir_rd && !m_prev;
    e_oe = dir_rd;
    if (dir_rd) e_out = ref_read(grp_sel);
    if (chk_load) begin
      m_inc[0] = chk_ff; m_inc[1] = chk_ap; m_inc[2] = chk_anc;
      m_out[0] = chk_ff; m_out[1] = chk_ap; m_out[2] = chk_anc;
      m_apv = chk_apv; m_ffv = chk_ffv; m_cks = chk_cks; m_st = chk_status;
    end
    if (wr) begin
      if (grp_sel == 2'd3) begin
        m_ctl = bus_in[4]; m_apv = bus_in[3]; m_ffv = bus_in[2];
      end else m_out[grp_sel] = bus_in;
    end
    m_prev = dir_rd;
  endtask

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got oe/data %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at the next negedge
  task automatic cyc(input logic d, input logic [1:0] s, input logic [4:0] b,
                     input logic ld, input string tag);
    string t;
    dir_rd = d; grp_sel = s; bus_in = b; chk_load = ld;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    t = tag;
    if (t == "") t = !e_oe ? "R1" : (s == 2'd3 ? "R7" : "R6");
    if (e_oe) check(t, {bus_oe, bus_out}, {e_oe, e_out});
    else      check(t, {bus_oe, 5'b0}, {1'b0, 5'b0});
  endtask

  task automatic set_chk(input logic [4:0] f, a, n, input logic [3:0] misc);
    chk_ff = f; chk_ap = a; chk_anc = n;
    {chk_apv, chk_ffv, chk_cks, chk_status} = misc;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got no end expected end of run");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; dir_rd = 1; grp_sel = 0; bus_in = 0; chk_load = 0;
    set_chk(5'h00, 5'h00, 5'h00, 4'h0);
    model_reset();
    repeat (3) @(negedge clk);
    check("R10", {bus_oe, bus_out}, 6'b0);
    rst_n = 1;
    // R8: control bit clear after reset, group 3 read shows checksum
    set_chk(5'h0A, 5'h15, 5'h1C, 4'b1111);
    cyc(1, 2'd0, 5'h00, 1, "R9");
    cyc(1, 2'd3, 5'h00, 0, "R8");
    cyc(1, 2'd0, 5'h00, 0, "R9");
    // first low sample writes nothing (R1), next writes group 1 (R2)
    cyc(0, 2'd0, 5'h1F, 0, "R1");
    cyc(0, 2'd1, 5'h03, 0, "R2");
    cyc(1, 2'd1, 5'h00, 0, "R2");
    cyc(1, 2'd0, 5'h00, 0, "R4");
    cyc(1, 2'd2, 5'h00, 0, "R4");
    cyc(1, 2'd1, 5'h00, 0, "R5");
    // R3: group 3 write, bits 1:0 ignored
    cyc(0, 2'd3, 5'h00, 0, "R1");
    cyc(0, 2'd3, 5'b10111, 0, "R3");
    cyc(1, 2'd3, 5'h00, 0, "R3");
    cyc(1, 2'd1, 5'h00, 0, "R6");
    // R8: write while control bit is 1 still lands in outgoing set
    cyc(0, 2'd2, 5'h00, 0, "R1");
    cyc(0, 2'd2, 5'h11, 0, "R8");
    cyc(0, 2'd3, 5'b00000, 0, "R3");
    cyc(1, 2'd2, 5'h00, 0, "R8");
    cyc(1, 2'd3, 5'h00, 0, "R7");
    // R9: load and host write at the same edge
    set_chk(5'h05, 5'h06, 5'h07, 4'b0101);
    cyc(0, 2'd0, 5'h00, 0, "R1");
    cyc(0, 2'd0, 5'h19, 1, "R9");
    cyc(1, 2'd0, 5'h00, 0, "R9");
    cyc(1, 2'd1, 5'h00, 0, "R9");
    // constrained random run
    for (int i = 0; i < 4000; i++) begin
      logic d;
      d = ($urandom_range(0, 3) == 0) ? !dir_rd : dir_rd;
      set_chk(5'($urandom), 5'($urandom), 5'($urandom), 4'($urandom));
      cyc(d, 2'($urandom), 5'($urandom), ($urandom_range(0, 9) == 0), "");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule